// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows a single DRAM bank from the controller's point of view. Each cycle it takes command strobes: activate with a row address, column read, column write, their auto-closing variants, precharge, and precharge-all. From its own elapsed-cycle counters it works out which commands are legal in the current cycle. The scheduler looks at the per-command permission flags before it issues anything. It also reads the open-row value to decide whether a request hits the page that is already open.

Every timing limit is a parameter in clock cycles. These cover activate-to-column, activate-to-close, read-to-close and close duration. The tracker enforces them by refusing early commands. A refused command leaves the bank untouched and produces a one-cycle error pulse. Auto-closing accesses mark the row for closure, and the tracker closes the row itself on the first cycle that all closing limits are met.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset, `bank_state` reads 0 (idle), `row_open` is 0, `open_row` is 0, `act_ok` is 1, `col_ok` is 0, `pre_ok` is 1 and `proto_err` is 0. `bank_state` encodes idle as 0, active as 1 and precharging as 2, and never takes the value 3.
- R2: An accepted activate latches `act_row`, and `open_row` then shows that value. `open_row` does not change while the row stays open. A second activate to an open bank is refused. `open_row` reads 0 while no row is open.
- R3: `col_ok` goes high exactly T_RCD cycles after the activate is accepted. A column command issued earlier is refused.
- R4: An explicit close (precharge or precharge-all) to an active bank is accepted only once T_RAS cycles have passed since the activate and T_RTP cycles have passed since the most recent read (plain or auto-closing). Writes do not restart the read-to-close wait.
- R5: After a close takes effect, `bank_state` reads 2 for exactly T_RP cycles and then 0. `act_ok` goes high T_RP cycles after the close.
- R6: After an auto-closing read or write, `col_ok` and `pre_ok` stay low. The row then closes on its own at the same edge where an explicit close would first have been accepted, as set by both the T_RAS and the T_RTP limits.
- R7: Two accepted activates are at least T_RAS + T_RP cycles apart.
- R8: Any sequence of reads and writes may be issued while the row is open, without changing the state or the open row and without raising errors.
- R9: A command whose permission flag is low is ignored. `proto_err` is high for the one cycle following it.
- R10: When more than one command strobe is high in the same cycle, all of them are ignored and `proto_err` pulses.
- R11: A precharge or precharge-all to an idle or already precharging bank is accepted without error, changes no state and does not restart the close timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_act | input | 1 | Activate strobe |
| act_row | input | ROW_W | Row address for activate |
| cmd_rd | input | 1 | Column read strobe |
| cmd_wr | input | 1 | Column write strobe |
| cmd_rda | input | 1 | Read with automatic close |
| cmd_wra | input | 1 | Write with automatic close |
| cmd_pre | input | 1 | Close this bank |
| cmd_prea | input | 1 | Close all banks (this bank included) |
| act_ok | output | 1 | Activate is legal this cycle |
| col_ok | output | 1 | Column commands are legal this cycle |
| pre_ok | output | 1 | Close commands are legal this cycle |
| row_open | output | 1 | A row is open |
| open_row | output | ROW_W | Open row address, 0 when closed |
| bank_state | output | 2 | 0 idle, 1 active, 2 precharging |
| proto_err | output | 1 | Pulse after a refused command |

## Verification
The hardest case to reach is an automatic close that the read-to-close limit delays rather than the activate-to-close limit. To reach it, the stimulus holds an activated row open past T_RAS and only then issues the auto-closing read, so the closing edge moves out by T_RTP. The bench also sends an explicit close during the read-to-close window, and the refusal shows at the ports as a row that stays open and an error pulse.

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int ROW_W = 14,
  parameter int T_RCD = 3,
  parameter int T_RAS = 8,
  parameter int T_RP  = 3,
  parameter int T_RTP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_act,
  input  logic [ROW_W-1:0] act_row,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_rda,
  input  logic             cmd_wra,
  input  logic             cmd_pre,
  input  logic             cmd_prea,
  output logic             act_ok,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             row_open,
  output logic [ROW_W-1:0] open_row,
  output logic [1:0]       bank_state,
  output logic             proto_err
);

  localparam int T_RC = T_RAS + T_RP;
  localparam int AW   = $clog2(T_RC + 1);
  localparam int RW   = $clog2(T_RTP + 1);
  localparam int PW   = $clog2(T_RP + 1);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_ACT = 2'd1, ST_PRE = 2'd2} st_t;

  st_t              st_q;
  logic [AW-1:0]    act_age;
  logic [RW-1:0]    rd_age;
  logic [PW-1:0]    pre_age;
  logic             ap_q;
  logic [ROW_W-1:0] row_q;
  logic             err_q;

  logic [6:0] strobes;
  logic       any_cmd, single, col_cmd, pre_cmd, rd_cmd;
  logic       pre_done, close_ready, auto_close;
  logic       acc_act, acc_col, acc_pre, bad;

  assign strobes = {cmd_act, cmd_rd, cmd_wr, cmd_rda, cmd_wra, cmd_pre, cmd_prea};
  assign any_cmd = |strobes;
  assign single  = $countones(strobes) == 1;
  assign col_cmd = cmd_rd | cmd_wr | cmd_rda | cmd_wra;
  assign pre_cmd = cmd_pre | cmd_prea;
  assign rd_cmd  = cmd_rd | cmd_rda;

  assign pre_done    = (st_q == ST_PRE) && (int'(pre_age) >= T_RP);
  assign close_ready = (int'(act_age) >= T_RAS) && (int'(rd_age) >= T_RTP);
  assign auto_close  = (st_q == ST_ACT) && ap_q && close_ready;

  assign act_ok = ((st_q == ST_IDLE) || pre_done) && (int'(act_age) >= T_RC);
  assign col_ok = (st_q == ST_ACT) && !ap_q && (int'(act_age) >= T_RCD);
  assign pre_ok = (st_q != ST_ACT) || (!ap_q && close_ready);

  assign acc_act = single && cmd_act && act_ok;
  assign acc_col = single && col_cmd && col_ok;
  assign acc_pre = single && pre_cmd && pre_ok && (st_q == ST_ACT);
  assign bad     = any_cmd && !(single && (cmd_act ? act_ok : col_cmd ? col_ok : pre_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      act_age <= AW'(T_RC);
      rd_age  <= RW'(T_RTP);
      pre_age <= PW'(T_RP);
      ap_q    <= 1'b0;
      row_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= bad;
      if (int'(act_age) < T_RC)  act_age <= act_age + 1'b1;
      if (int'(rd_age)  < T_RTP) rd_age  <= rd_age + 1'b1;
      if (int'(pre_age) < T_RP)  pre_age <= pre_age + 1'b1;
      if (acc_act) begin
        st_q    <= ST_ACT;
        row_q   <= act_row;
        act_age <= AW'(1);
        rd_age  <= RW'(T_RTP);
        ap_q    <= 1'b0;
      end else if (acc_col) begin
        if (rd_cmd) rd_age <= RW'(1);
        if (cmd_rda | cmd_wra) ap_q <= 1'b1;
      end else if (acc_pre || auto_close) begin
        st_q    <= ST_PRE;
        pre_age <= PW'(1);
        ap_q    <= 1'b0;
      end else if (pre_done) begin
        st_q <= ST_IDLE;
      end
    end
  end

  assign bank_state = st_q;
  assign row_open   = (st_q == ST_ACT);
  assign open_row   = row_open ? row_q : '0;
  assign proto_err  = err_q;

  a_r1_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bank_state != 2'd3);

  a_r2_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (row_open && $past(row_open)) |-> $stable(open_row));

  a_r5_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_state == ST_IDLE) |-> ($past(bank_state) != ST_ACT));

  a_r6_close_limits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(row_open) |-> ($past(act_age) >= AW'(T_RAS) && $past(rd_age) >= RW'(T_RTP)));

  a_r7_act_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_open) |-> ($past(act_age) >= AW'(T_RC)));

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(any_cmd));

endmodule

// File: tb/sim_dram_bank_tracker.sv
module sim_dram_bank_tracker;
  localparam int ROW_W = 14;
  localparam int T_RCD = 3;
  localparam int T_RAS = 8;
  localparam int T_RP  = 3;
  localparam int T_RTP = 2;

  localparam logic [6:0] C_ACT  = 7'b1000000;
  localparam logic [6:0] C_RD   = 7'b0100000;
  localparam logic [6:0] C_WR   = 7'b0010000;
  localparam logic [6:0] C_RDA  = 7'b0001000;
  localparam logic [6:0] C_WRA  = 7'b0000100;
  localparam logic [6:0] C_PRE  = 7'b0000010;
  localparam logic [6:0] C_PREA = 7'b0000001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_act, cmd_rd, cmd_wr, cmd_rda, cmd_wra, cmd_pre, cmd_prea;
  logic [ROW_W-1:0] act_row;
  logic act_ok, col_ok, pre_ok, row_open, proto_err;
  logic [ROW_W-1:0] open_row;
  logic [1:0] bank_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dram_bank_tracker #(.ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RTP(T_RTP)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_act(cmd_act), .act_row(act_row), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_rda(cmd_rda), .cmd_wra(cmd_wra), .cmd_pre(cmd_pre),
    .cmd_prea(cmd_prea), .act_ok(act_ok), .col_ok(col_ok), .pre_ok(pre_ok),
    .row_open(row_open), .open_row(open_row), .bank_state(bank_state), .proto_err(proto_err));

  task automatic chk(input string req, input string what, input int actual, input int expv);
    checks++;
    if (actual != expv) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, actual, expv);
    end
  endtask

  task automatic cmd(input logic [6:0] v, input logic [ROW_W-1:0] row);
    {cmd_act, cmd_rd, cmd_wr, cmd_rda, cmd_wra, cmd_pre, cmd_prea} = v;
    act_row = row;
    @(negedge clk);
    {cmd_act, cmd_rd, cmd_wr, cmd_rda, cmd_wra, cmd_pre, cmd_prea} = '0;
    act_row = '0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    {cmd_act, cmd_rd, cmd_wr, cmd_rda, cmd_wra, cmd_pre, cmd_prea} = '0;
    act_row = '0;
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "state", bank_state, 0);
    chk("R1", "row_open", row_open, 0);
    chk("R1", "open_row", open_row, 0);
    chk("R1", "act_ok", act_ok, 1);
    chk("R1", "col_ok", col_ok, 0);
    chk("R1", "pre_ok", pre_ok, 1);
    chk("R1", "proto_err", proto_err, 0);
  endtask

  task automatic t_rcd();
    do_reset();
    cmd(C_ACT, 14'h1234);
    for (int k = 1; k <= T_RCD; k++) begin
      chk("R3", $sformatf("col_ok k=%0d", k), col_ok, (k >= T_RCD) ? 1 : 0);
      if (k < T_RCD) tick(1);
    end
    chk("R2", "open_row", open_row, 14'h1234);
    chk("R1", "state active", bank_state, 1);
    cmd(C_RD, '0);
    chk("R3", "read at limit no err", proto_err, 0);
  endtask

  task automatic t_pre();
    do_reset();
    cmd(C_ACT, 14'h0055);
    tick(T_RAS - 2);
    chk("R4", "pre_ok before tRAS", pre_ok, 0);
    tick(1);
    chk("R4", "pre_ok at tRAS", pre_ok, 1);
    cmd(C_PRE, '0);
    for (int j = 1; j <= T_RP; j++) begin
      chk("R5", $sformatf("state j=%0d", j), bank_state, 2);
      chk("R5", $sformatf("act_ok j=%0d", j), act_ok, (j >= T_RP) ? 1 : 0);
      chk("R2", $sformatf("open_row closed j=%0d", j), open_row, 0);
      if (j < T_RP) tick(1);
    end
    cmd(C_ACT, 14'h00AB);
    chk("R7", "reopen after tRAS+tRP", row_open, 1);
    chk("R2", "new row", open_row, 14'h00AB);
  endtask

  task automatic t_prea();
    do_reset();
    cmd(C_ACT, 14'h0100);
    tick(T_RAS - 1);
    cmd(C_PREA, '0);
    chk("R4", "prea closes", row_open, 0);
    tick(T_RP);
    chk("R5", "idle after tRP", bank_state, 0);
  endtask

  task automatic t_rtp();
    do_reset();
    cmd(C_ACT, 14'h0200);
    tick(T_RAS - 1);
    cmd(C_RD, '0);
    chk("R4", "pre_ok after read", pre_ok, 0);
    cmd(C_PRE, '0);
    chk("R9", "early pre err", proto_err, 1);
    chk("R9", "early pre ignored", row_open, 1);
    chk("R4", "pre_ok after tRTP", pre_ok, 1);
    tick(1);
    chk("R9", "err one cycle", proto_err, 0);
    cmd(C_WR, '0);
    chk("R4", "write keeps pre_ok", pre_ok, 1);
  endtask

  task automatic t_rda();
    do_reset();
    cmd(C_ACT, 14'h0300);
    tick(T_RCD - 1);
    cmd(C_RDA, '0);
    chk("R6", "col_ok pending", col_ok, 0);
    chk("R6", "pre_ok pending", pre_ok, 0);
    cmd(C_RD, '0);
    chk("R6", "read while pending err", proto_err, 1);
    tick(T_RAS - T_RCD - 2);
    chk("R6", "open at tRAS", row_open, 1);
    tick(1);
    chk("R6", "closed after tRAS", row_open, 0);
    chk("R6", "precharging", bank_state, 2);
    do_reset();
    cmd(C_ACT, 14'h0301);
    tick(T_RAS);
    cmd(C_RDA, '0);
    tick(T_RTP - 1);
    chk("R6", "late rda open at tRTP", row_open, 1);
    tick(1);
    chk("R6", "late rda closed", row_open, 0);
  endtask

  task automatic t_mix();
    int errs = 0;
    do_reset();
    cmd(C_ACT, 14'h0400);
    tick(T_RCD - 1);
    cmd(C_RD, '0);  errs += proto_err;
    cmd(C_WR, '0);  errs += proto_err;
    cmd(C_RD, '0);  errs += proto_err;
    cmd(C_WRA, '0); errs += proto_err;
    chk("R8", "mix no errors", errs, 0);
    chk("R8", "row kept", open_row, 14'h0400);
    tick(T_RAS - 7);
    chk("R6", "wra open at tRAS", row_open, 1);
    tick(1);
    chk("R6", "wra closed", row_open, 0);
  endtask

  task automatic t_illegal();
    do_reset();
    cmd(C_RD, '0);
    chk("R9", "read idle err", proto_err, 1);
    chk("R9", "read idle ignored", bank_state, 0);
    cmd(C_ACT, 14'h0AAA);
    chk("R9", "err cleared", proto_err, 0);
    cmd(C_RD, '0);
    chk("R3", "early read err", proto_err, 1);
    cmd(C_ACT, 14'h0BBB);
    chk("R2", "second act err", proto_err, 1);
    chk("R2", "row unchanged", open_row, 14'h0AAA);
    tick(T_RAS - 3);
    cmd(C_WR | C_PRE, '0);
    chk("R10", "multi err", proto_err, 1);
    chk("R10", "multi pre ignored", row_open, 1);
  endtask

  task automatic t_pre_idle();
    do_reset();
    cmd(C_PRE, '0);
    chk("R11", "pre idle no err", proto_err, 0);
    chk("R11", "pre idle state", bank_state, 0);
    cmd(C_PREA, '0);
    chk("R11", "prea idle act_ok", act_ok, 1);
    cmd(C_ACT, 14'h0010);
    tick(T_RAS - 1);
    cmd(C_PRE, '0);
    cmd(C_PRE, '0);
    chk("R11", "pre while precharging no err", proto_err, 0);
    chk("R11", "still precharging", bank_state, 2);
    tick(T_RP - 2);
    chk("R11", "timer not restarted", act_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rcd();
    t_pre();
    t_prea();
    t_rtp();
    t_rda();
    t_mix();
    t_illegal();
    t_pre_idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule